// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Fractional Stop Period

This block is one asynchronous serial transmit channel. Software or a host engine writes a byte into a one-entry holding register. The block then sends it on a single line. The frame starts with a low start bit and carries 5 to 8 data bits, least significant bit first. A parity bit may follow. The frame ends with a high stop period whose length is set in sixteenths of a bit. The block is clocked from the system clock and advances only on a single-cycle enable that pulses at sixteen times the bit rate.

Framing is set by mode inputs: character length, parity mode, parity polarity, a 4-bit stop code, and a flow-control enable. When flow control is on, a frame may start only while the clear-to-send input is high. Two command strobes switch the transmitter on and off. Two status outputs are provided:

- `tx_ready` shows that a byte can be written.
- `tx_empty` shows that nothing is queued or being sent.

A byte written during a frame waits in the holding register. It begins exactly when the stop period ends, with no idle gap.

Top module: `uart_tx_fracstop`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 0, `tx_empty` is 1, and the transmitter is off.
- R2: A frame is a low start bit followed by `cfg_len`+5 data bits, least significant bit first (`cfg_len` 0 = 5 bits … 3 = 8 bits). Each of these bits lasts exactly 16 enable ticks.
- R3: The parity mode `cfg_par_mode` selects the parity bit, which lasts 16 ticks:
  - 0: a computed parity bit is sent. It is the XOR of the data bits, inverted when `cfg_par_odd` is 1.
  - 1: the parity bit is fixed at the value of `cfg_par_odd`.
  - 2 or 3: no parity bit is sent.
- R4: For stop codes 0 to 7 with character lengths of 6 to 8 bits, the line stays high for 9 + code ticks after the last data or parity bit.
- R5: For stop codes 8 to 15, the stop period is 17 + code ticks, for any character length.
- R6: For 5-bit characters with stop codes 0 to 7, the stop period is 17 + code ticks (eight ticks longer).
- R7: `tx_ready` equals "transmitter on and holding register empty". `tx_empty` is 1 exactly when the holding register is empty and no frame is in progress.
- R8: A write while the holding register is full is ignored. The held byte is not changed.
- R9: With `cfg_cts_en` = 1, a frame starts only on a tick where `cts_ok` is 1. A frame already started ignores later changes of `cts_ok`.
- R10: The command strobes work as follows:
  - `cmd_tx_off` turns the transmitter off and wins when both strobes are high.
  - While off, writes are ignored and no new frame starts.
  - A frame that has already started completes.
  - A held byte waits until `cmd_tx_on`.
- R11: A byte held while a frame is in progress starts its start bit on the tick that ends the stop period, so the stop period is not stretched.
- R12: From idle, a frame starts on the first enable tick on which the holding register is full, the transmitter is on and clear-to-send allows it. `txd` falls on the clock edge of that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| cfg_len | input | 2 | Character length minus 5 |
| cfg_par_mode | input | 2 | 0 computed parity, 1 fixed parity, 2/3 none |
| cfg_par_odd | input | 1 | Odd parity, or the value of the fixed parity bit |
| cfg_stop | input | 4 | Stop period code |
| cfg_cts_en | input | 1 | Gate frame starts with `cts_ok` |
| cts_ok | input | 1 | Clear-to-send, active high |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| cmd_tx_on | input | 1 | Turn transmitter on |
| cmd_tx_off | input | 1 | Turn transmitter off |
| txd | output | 1 | Serial output, idle high |
| tx_ready | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding and shift registers both empty |

## Verification
Each fault shows up at the ports within a bounded time:

- A wrong bit or phase counter changes when an edge of `txd` occurs. Bit counts are off within the first bit (16 ticks) of a frame. A stop-length decode fault shows at the next start bit of a back-to-back pair.
- A holding-register flag that is set or cleared wrongly shows at `tx_ready` or `tx_empty` on the next clock.
- A corrupted held byte shows in the data bits of the following frame.
- Flow-control or command faults show as a start bit one tick too early or missing where the line must stay high.

Since every clock is compared, each fault is reported at the first cycle it becomes visible.

// File: rtl/uart_txfs_pkg.sv
package uart_txfs_pkg;

   typedef enum logic [2:0] {
      TXS_IDLE,
      TXS_START,
      TXS_DATA,
      TXS_PAR,
      TXS_STOP
   } txs_e;

   // Stop period in 16x ticks; short characters get eight extra ticks on the low codes.
   function automatic logic [5:0] stop_ticks(input logic [3:0] code, input logic short_char);
      logic [5:0] base;
      if (code[3]) base = 6'd17 + {2'b00, code};
      else         base = 6'd9 + {2'b00, code} + (short_char ? 6'd8 : 6'd0);
      return base;
   endfunction

   // Parity bit for the enabled data bits; fixed mode returns the polarity bit.
   function automatic logic par_value(input logic [7:0] data, input logic [1:0] len,
                                      input logic fixed, input logic odd);
      logic [7:0] mask;
      mask = 8'hFF >> (2'd3 - len);
      if (fixed) return odd;
      return (^(data & mask)) ^ odd;
   endfunction

endpackage

// File: rtl/uart_txfs_stoplen.sv
module uart_txfs_stoplen #(
   parameter int CNT_W = 6
) (
   input  logic [3:0]       cfg_stop,
   input  logic [1:0]       cfg_len,
   output logic [CNT_W-1:0] stop_len
);
   import uart_txfs_pkg::*;

   generate
      if (CNT_W < 6) begin : g_bad_width
         $error("uart_txfs_stoplen: CNT_W must hold 32 ticks");
      end
   endgenerate

   always_comb begin
      stop_len = CNT_W'(stop_ticks(cfg_stop, cfg_len == 2'd0));
   end
endmodule

// File: rtl/uart_txfs_hold.sv
module uart_txfs_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cmd_on,
   input  logic              cmd_off,
   input  logic              load,
   output logic              enabled,
   output logic              hold_valid,
   output logic [DATA_W-1:0] hold_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enabled    <= 1'b0;
         hold_valid <= 1'b0;
         hold_data  <= '0;
      end else begin
         if (cmd_off)     enabled <= 1'b0;
         else if (cmd_on) enabled <= 1'b1;

         if (load) begin
            hold_valid <= 1'b0;
         end else if (wr_en && enabled && !hold_valid) begin
            hold_valid <= 1'b1;
            hold_data  <= wr_data;
         end
      end
   end
endmodule

// File: rtl/uart_txfs_frame.sv
module uart_txfs_frame #(
   parameter int OVERSAMPLE = 16,
   parameter bit HAS_PARITY = 1'b1,
   parameter int CNT_W      = $clog2(2 * OVERSAMPLE + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start_ok,
   input  logic [7:0]       hold_data,
   input  logic [1:0]       cfg_len,
   input  logic [1:0]       cfg_par_mode,
   input  logic             cfg_par_odd,
   input  logic [CNT_W-1:0] stop_len,
   output logic             load,
   output logic             busy,
   output logic             txd
);
   import uart_txfs_pkg::*;

   localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVERSAMPLE - 1);

   generate
      if (OVERSAMPLE != 16) begin : g_bad_ovs
         $error("uart_txfs_frame: stop periods are defined in sixteenths");
      end
   endgenerate

   txs_e             state;
   logic [CNT_W-1:0] cnt;
   logic [2:0]       bit_idx;
   logic [7:0]       shreg;
   logic             par_r;
   logic             par_calc;
   logic             use_par;
   logic             bit_end;
   logic             stop_end;
   logic             last_bit;

   generate
      if (HAS_PARITY) begin : g_par
         assign use_par  = ~cfg_par_mode[1];
         assign par_calc = par_value(hold_data, cfg_len, cfg_par_mode[0], cfg_par_odd);
      end else begin : g_nopar
         assign use_par  = 1'b0;
         assign par_calc = 1'b0;
      end
   endgenerate

   assign bit_end  = (cnt == BIT_LAST);
   assign stop_end = (cnt == stop_len - CNT_W'(1));
   assign last_bit = (bit_idx == ({1'b0, cfg_len} + 3'd4));
   assign load     = tick && start_ok &&
                     ((state == TXS_IDLE) || ((state == TXS_STOP) && stop_end));
   assign busy     = (state != TXS_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= TXS_IDLE;
         cnt     <= '0;
         bit_idx <= '0;
         shreg   <= '0;
         par_r   <= 1'b0;
      end else if (tick) begin
         if (load) begin
            state   <= TXS_START;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= hold_data;
            par_r   <= par_calc;
         end else begin
            case (state)
               TXS_START: begin
                  if (bit_end) begin
                     state <= TXS_DATA;
                     cnt   <= '0;
                  end else cnt <= cnt + CNT_W'(1);
               end
               TXS_DATA: begin
                  if (bit_end) begin
                     cnt     <= '0;
                     shreg   <= shreg >> 1;
                     bit_idx <= bit_idx + 3'd1;
                     if (last_bit) state <= use_par ? TXS_PAR : TXS_STOP;
                  end else cnt <= cnt + CNT_W'(1);
               end
               TXS_PAR: begin
                  if (bit_end) begin
                     state <= TXS_STOP;
                     cnt   <= '0;
                  end else cnt <= cnt + CNT_W'(1);
               end
               TXS_STOP: begin
                  if (stop_end) state <= TXS_IDLE;
                  else          cnt   <= cnt + CNT_W'(1);
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (state)
         TXS_START: txd = 1'b0;
         TXS_DATA:  txd = shreg[0];
         TXS_PAR:   txd = par_r;
         default:   txd = 1'b1;
      endcase
   end
endmodule

// File: rtl/uart_tx_fracstop.sv
module uart_tx_fracstop #(
   parameter int OVERSAMPLE = 16,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick16,
   input  logic [1:0] cfg_len,
   input  logic [1:0] cfg_par_mode,
   input  logic       cfg_par_odd,
   input  logic [3:0] cfg_stop,
   input  logic       cfg_cts_en,
   input  logic       cts_ok,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       cmd_tx_on,
   input  logic       cmd_tx_off,
   output logic       txd,
   output logic       tx_ready,
   output logic       tx_empty
);
   localparam int CNT_W = $clog2(2 * OVERSAMPLE + 1);

   logic             tx_enabled;
   logic             hold_valid;
   logic [7:0]       hold_data;
   logic             load;
   logic             busy;
   logic             start_ok;
   logic [CNT_W-1:0] stop_len;

   assign start_ok = hold_valid && tx_enabled && (!cfg_cts_en || cts_ok);
   assign tx_ready = tx_enabled && !hold_valid;
   assign tx_empty = !hold_valid && !busy;

   uart_txfs_hold #(.DATA_W(8)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .cmd_on     (cmd_tx_on),
      .cmd_off    (cmd_tx_off),
      .load       (load),
      .enabled    (tx_enabled),
      .hold_valid (hold_valid),
      .hold_data  (hold_data)
   );

   uart_txfs_stoplen #(.CNT_W(CNT_W)) u_stoplen (
      .cfg_stop (cfg_stop),
      .cfg_len  (cfg_len),
      .stop_len (stop_len)
   );

   uart_txfs_frame #(
      .OVERSAMPLE (OVERSAMPLE),
      .HAS_PARITY (HAS_PARITY),
      .CNT_W      (CNT_W)
   ) u_frame (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick16),
      .start_ok     (start_ok),
      .hold_data    (hold_data),
      .cfg_len      (cfg_len),
      .cfg_par_mode (cfg_par_mode),
      .cfg_par_odd  (cfg_par_odd),
      .stop_len     (stop_len),
      .load         (load),
      .busy         (busy),
      .txd          (txd)
   );
endmodule

// File: rtl/uart_tx_fracstop_chk.sv
module uart_tx_fracstop_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_cts_en,
   input logic       cts_ok,
   input logic       txd,
   input logic       tx_empty,
   input logic       tx_enabled,
   input logic       hold_valid,
   input logic [7:0] hold_data,
   input logic       load
);
   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> txd);

   assert_hold_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_valid && !load) |=> (hold_valid && $stable(hold_data)));

   assert_cts_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load && cfg_cts_en) |-> cts_ok);

   assert_no_start_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> tx_enabled);

   assert_load_frees_R11: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !hold_valid);

   assert_start_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !txd);
endmodule

bind uart_tx_fracstop uart_tx_fracstop_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_cts_en (cfg_cts_en),
   .cts_ok     (cts_ok),
   .txd        (txd),
   .tx_empty   (tx_empty),
   .tx_enabled (tx_enabled),
   .hold_valid (hold_valid),
   .hold_data  (hold_data),
   .load       (load)
);

// File: tb/uart_tx_fracstop_bench.sv
module uart_tx_fracstop_bench;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic [1:0] cfg_len = 2'd3;
   logic [1:0] cfg_par_mode = 2'd2;
   logic       cfg_par_odd = 1'b0;
   logic [3:0] cfg_stop = 4'd7;
   logic       cfg_cts_en = 1'b0;
   logic       cts_ok = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       cmd_tx_on = 1'b0;
   logic       cmd_tx_off = 1'b0;
   logic       txd, tx_ready, tx_empty;

   uart_tx_fracstop u_uart_tx_fracstop (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .cfg_len(cfg_len),
      .cfg_par_mode(cfg_par_mode), .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop),
      .cfg_cts_en(cfg_cts_en), .cts_ok(cts_ok), .wr_en(wr_en), .wr_data(wr_data),
      .cmd_tx_on(cmd_tx_on), .cmd_tx_off(cmd_tx_off),
      .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
   );

   int    checks = 0;
   int    errors = 0;
   int    cyc = 0;
   bit    run_cmp = 1'b0;
   string scen = "R12";

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   // Tick every third clock, driven away from the active edge.
   int tcnt = 0;
   always @(negedge clk) begin
      tcnt   = (tcnt == 2) ? 0 : tcnt + 1;
      tick16 = (tcnt == 0);
   end

   // Behavioural reference: per-tick line levels queued at frame start.
   bit         m_en, m_hv, m_busy, m_txd;
   logic [7:0] m_hd;
   int         m_seg;
   int         lvl_q[$];
   int         seg_q[$];

   task automatic push_lv(input int lvl, input int n, input int seg);
      for (int i = 0; i < n; i++) begin
         lvl_q.push_back(lvl);
         seg_q.push_back(seg);
      end
   endtask

   task automatic build_frame(input logic [7:0] d);
      int nb, ones, p, s;
      nb   = int'(cfg_len) + 5;
      ones = 0;
      push_lv(0, 15, 2);
      for (int i = 0; i < nb; i++) begin
         push_lv(int'(d[i]), 16, 2);
         ones += int'(d[i]);
      end
      if (cfg_par_mode == 2'd0) begin
         p = (ones % 2) ^ int'(cfg_par_odd);
         push_lv(p, 16, 3);
      end else if (cfg_par_mode == 2'd1) begin
         push_lv(int'(cfg_par_odd), 16, 3);
      end
      if (cfg_stop >= 4'd8) s = 17 + int'(cfg_stop);
      else                  s = 9 + int'(cfg_stop) + ((nb == 5) ? 8 : 0);
      push_lv(1, s, 4);
   endtask

   always @(posedge clk) begin : ref_model
      bit en0, hv0, cond, st;
      if (!rst_n) begin
         m_en = 0; m_hv = 0; m_busy = 0; m_txd = 1; m_seg = 0; m_hd = 8'h00;
         lvl_q.delete(); seg_q.delete();
      end else begin
         en0  = m_en;
         hv0  = m_hv;
         st   = 0;
         cond = en0 && hv0 && (!cfg_cts_en || cts_ok);
         if (tick16) begin
            if (!m_busy) st = cond;
            else if (lvl_q.size() > 0) begin
               m_txd = (lvl_q.pop_front() != 0);
               m_seg = seg_q.pop_front();
            end else if (cond) st = 1;
            else begin
               m_busy = 0; m_txd = 1; m_seg = 0;
            end
         end
         if (st) begin
            build_frame(m_hd);
            m_hv = 0; m_busy = 1; m_txd = 0; m_seg = 2;
         end
         if (wr_en && en0 && !hv0) begin
            m_hv = 1;
            m_hd = wr_data;
         end
         if (cmd_tx_off)     m_en = 0;
         else if (cmd_tx_on) m_en = 1;
      end
   end

   function automatic string line_req();
      if (m_seg == 3) return "R3";
      if (m_seg == 4) begin
         if (cfg_stop >= 4'd8) return "R5";
         if (cfg_len == 2'd0)  return "R6";
         return "R4";
      end
      if (m_seg == 2) return (scen == "R12") ? "R2" : scen;
      return scen;
   endfunction

   always @(negedge clk) begin
      if (rst_n && run_cmp) begin
         check(txd == m_txd, line_req(), "txd", int'(txd), int'(m_txd));
         check(tx_ready == (m_en && !m_hv), "R7", "tx_ready", int'(tx_ready), int'(m_en && !m_hv));
         check(tx_empty == (!m_hv && !m_busy), "R7", "tx_empty", int'(tx_empty), int'(!m_hv && !m_busy));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic pulse_wr(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic send(input logic [7:0] d);
      for (int i = 0; i < 4000 && !tx_ready; i++) @(negedge clk);
      pulse_wr(d);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 4000 && !tx_empty; i++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic cmd(input bit on, input bit off);
      @(negedge clk);
      cmd_tx_on = on; cmd_tx_off = off;
      @(negedge clk);
      cmd_tx_on = 1'b0; cmd_tx_off = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      check(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
      check(tx_ready == 1'b0, "R1", "tx_ready after reset", int'(tx_ready), 0);
      check(tx_empty == 1'b1, "R1", "tx_empty after reset", int'(tx_empty), 1);
      run_cmp = 1'b1;

      // R10: write while off is refused
      scen = "R10";
      pulse_wr(8'h55);
      repeat (100) @(negedge clk);
      check(tx_empty == 1'b1, "R10", "tx_empty after write while off", int'(tx_empty), 1);
      cmd(1'b1, 1'b0);
      check(tx_ready == 1'b1, "R7", "tx_ready once on", int'(tx_ready), 1);

      // R12: single frame from idle
      scen = "R12";
      send(8'hA5);
      wait_idle();

      // R11 back to back, R8 overfill ignored
      scen = "R11";
      cfg_stop = 4'd15;
      send(8'h3C);
      send(8'hC3);
      pulse_wr(8'hFF);
      check(tx_ready == 1'b0, "R8", "tx_ready with full holding", int'(tx_ready), 0);
      wait_idle();

      // R4 R5 R6: all stop codes at 8-bit and 5-bit lengths
      scen = "R2";
      for (int l = 0; l < 2; l++) begin
         for (int c = 0; c < 16; c++) begin
            cfg_len  = (l == 0) ? 2'd3 : 2'd0;
            cfg_stop = 4'(c);
            send(8'(c * 37 + 11));
            send(8'(~(c * 37 + 11)));
            wait_idle();
         end
      end

      // R3: parity modes and polarity at 7- and 6-bit lengths
      scen = "R3";
      cfg_stop = 4'd3;
      for (int m = 0; m < 3; m++) begin
         for (int o = 0; o < 2; o++) begin
            for (int l = 1; l < 3; l++) begin
               cfg_par_mode = 2'(m);
               cfg_par_odd  = 1'(o);
               cfg_len      = 2'(l);
               send(8'(8'h6B + m * 16 + o * 5 + l));
               send(8'(8'h94 ^ (m + l)));
               wait_idle();
            end
         end
      end

      // R9: clear-to-send gating only at frame start
      scen = "R9";
      cfg_par_mode = 2'd2; cfg_len = 2'd3; cfg_stop = 4'd8;
      cfg_cts_en = 1'b1; cts_ok = 1'b0;
      send(8'h96);
      repeat (200) @(negedge clk);
      check(txd == 1'b1, "R9", "txd held while cts low", int'(txd), 1);
      check(tx_empty == 1'b0, "R9", "tx_empty while blocked", int'(tx_empty), 0);
      cts_ok = 1'b1;
      for (int i = 0; i < 20 && txd; i++) @(negedge clk);
      repeat (50) @(negedge clk);
      cts_ok = 1'b0;
      wait_idle();
      check(tx_empty == 1'b1, "R9", "frame completed despite cts drop", int'(tx_empty), 1);
      cfg_cts_en = 1'b0; cts_ok = 1'b1;

      // R10: turn off mid-frame, held byte waits, both strobes -> off
      scen = "R10";
      cfg_stop = 4'd15;
      send(8'h81);
      send(8'h7E);
      cmd(1'b0, 1'b1);
      repeat (1500) @(negedge clk);
      check(txd == 1'b1, "R10", "line idle after off", int'(txd), 1);
      check(tx_empty == 1'b0, "R10", "held byte kept while off", int'(tx_empty), 0);
      cmd(1'b1, 1'b1);
      repeat (200) @(negedge clk);
      check(tx_ready == 1'b0, "R10", "off wins over on", int'(tx_ready), 0);
      check(txd == 1'b1, "R10", "no start after both strobes", int'(txd), 1);
      cmd(1'b1, 1'b0);
      wait_idle();
      check(tx_empty == 1'b1, "R10", "held byte sent after on", int'(tx_empty), 1);

      repeat (10) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule